// File: doc/BRIEF.md
# 48-bit Task File Shadow Registers

This block keeps the command-block registers of an emulated legacy ATA channel and turns a command write into a host-to-device register frame. Software reaches it through a byte-wide port addressed by I/O address. The sector count, the three LBA bytes and the features register each remember the last two bytes written. This lets a 48-bit command be set up by writing each register twice, first with the high-order byte and then with the low-order byte.

A read of a count or LBA register returns one of the two stored bytes. Bit 7 of the device control register makes the choice (called HOB here). Any write into the command block clears that bit. Writing the command register takes a snapshot of every shadow byte and sends it as five 32-bit words over a valid/ready stream. While that frame is still being sent, a further command write is dropped. The error and status bytes come from the device side and are only read back.

Top module: `tfs_shadow_top`

## Requirements
- R1: After synchronous reset, all shadow bytes and the device control register are zero, `fis_valid` is low and `io_rdata` is zero.
- R2: A write to the features, sector count or any LBA register moves the stored current byte to the previous slot and stores the new byte as current, so only the last two writes survive.
- R3: A read (`io_rdata` updates at the clock edge that samples `io_rd`) of sector count or an LBA register returns the current byte when HOB (device control bit 7) is 0 and the previous byte when HOB is 1.
- R4: With CHANNEL=0 the command block sits at 1F0h–1F7h and device control at 3F6h. With CHANNEL=1 they sit at 170h–177h and 376h. Writes to any other address change nothing, and reads there return 00h.
- R5: Any write to a command-block address (base+0 to base+7) clears HOB and leaves the other control bits as they were.
- R6: Reads at base+1 return `dev_error`, and reads at base+7 or the control address return `dev_status`. Reads at base+6 return the last byte written there.
- R7: A command write (base+7) when no frame is pending raises `fis_valid` on the next cycle with words, LSB first. Word0 = {feat_cur, cmd, 80h, 27h}. Word1 = {device, lba_hi_cur, lba_mid_cur, lba_lo_cur}. Word2 = {feat_prev, lba_hi_prev, lba_mid_prev, lba_lo_prev}. Word3 = {control with bit 7 clear, 00h, cnt_prev, cnt_cur}. Word4 = 0.
- R8: Words go out in order, one per cycle where `fis_valid` and `fis_ready` are both high. Data and `fis_last` hold while the stream is stalled. `fis_last` marks word 4, and `fis_valid` drops after it is taken.
- R9: A command write while a frame is pending is ignored. The frame in flight is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_addr | input | 10 | I/O address |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| dev_status | input | 8 | Status byte from device side |
| dev_error | input | 8 | Error byte from device side |
| fis_valid | output | 1 | Frame word valid |
| fis_ready | input | 1 | Frame word accepted |
| fis_data | output | 32 | Frame word |
| fis_last | output | 1 | Final word of frame |

## Verification
The bench writes a register three times to show the oldest byte is dropped. A design that kept a deeper history, or shifted in the wrong direction, would return the wrong byte under one of the two HOB settings. It checks that any command-block write clears HOB, which a design that cleared it only on control writes would fail. It writes to the other channel's addresses, which a loose decoder would accept. It checks the exact frame bytes, so swapped current and previous bytes show as a wrong word 1 or word 2. It also issues a second command mid-frame, where a design without rejection would change the snapshot or send an extra frame.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_FEAT, SEL_CNT, SEL_LO, SEL_MID, SEL_HI,
    SEL_DEV, SEL_CMD, SEL_CTL
  } tfs_sel_e;

  localparam int NUM_PAIRS = 5;
  localparam int P_FEAT    = 0;
  localparam int P_CNT     = 1;
  localparam int P_LO      = 2;
  localparam int P_MID     = 3;
  localparam int P_HI      = 4;

  localparam logic [7:0] FIS_TYPE_H2D = 8'h27;
  localparam logic [7:0] FIS_CMD_FLAG = 8'h80;
  localparam logic [7:0] HOB_CLR_MASK = 8'h7F;

  typedef struct packed {
    logic [7:0] feat_cur;
    logic [7:0] feat_prev;
    logic [7:0] cnt_cur;
    logic [7:0] cnt_prev;
    logic [7:0] lo_cur;
    logic [7:0] lo_prev;
    logic [7:0] mid_cur;
    logic [7:0] mid_prev;
    logic [7:0] hi_cur;
    logic [7:0] hi_prev;
    logic [7:0] dev;
    logic [7:0] cmd;
    logic [7:0] ctl;
  } tfs_snap_t;

  function automatic tfs_sel_e pair_sel(input int idx);
    case (idx)
      P_FEAT:  return SEL_FEAT;
      P_CNT:   return SEL_CNT;
      P_LO:    return SEL_LO;
      P_MID:   return SEL_MID;
      P_HI:    return SEL_HI;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [4:0][31:0] build_frame(input tfs_snap_t s);
    logic [4:0][31:0] w;
    w[0] = {s.feat_cur, s.cmd, FIS_CMD_FLAG, FIS_TYPE_H2D};
    w[1] = {s.dev, s.hi_cur, s.mid_cur, s.lo_cur};
    w[2] = {s.feat_prev, s.hi_prev, s.mid_prev, s.lo_prev};
    w[3] = {s.ctl & HOB_CLR_MASK, 8'h00, s.cnt_prev, s.cnt_cur};
    w[4] = 32'h0;
    return w;
  endfunction

endpackage

// File: rtl/tfs_decode.sv
module tfs_decode
  import tfs_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CMD_BASE = 'h1F0,
  parameter int CTL_ADDR = 'h3F6
) (
  input  logic [ADDR_W-1:0] io_addr,
  output tfs_sel_e          sel,
  output logic              blk_hit
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(CMD_BASE);
  localparam logic [ADDR_W-1:0] CTL_V  = ADDR_W'(CTL_ADDR);

  always_comb begin
    sel     = SEL_NONE;
    blk_hit = 1'b0;
    if (io_addr == CTL_V) begin
      sel = SEL_CTL;
    end else if (io_addr[ADDR_W-1:3] == BASE_V[ADDR_W-1:3]) begin
      blk_hit = 1'b1;
      case (io_addr[2:0])
        3'd0:    sel = SEL_DATA;
        3'd1:    sel = SEL_FEAT;
        3'd2:    sel = SEL_CNT;
        3'd3:    sel = SEL_LO;
        3'd4:    sel = SEL_MID;
        3'd5:    sel = SEL_HI;
        3'd6:    sel = SEL_DEV;
        default: sel = SEL_CMD;
      endcase
    end
  end

endmodule

// File: rtl/tfs_pair_regs.sv
module tfs_pair_regs #(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      we,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] cur,
  output logic [N-1:0][W-1:0] prev
);

  for (genvar g = 0; g < N; g++) begin : g_pair
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q  <= '0;
        prev_q <= '0;
      end else if (we[g]) begin
        prev_q <= cur_q;
        cur_q  <= wdata;
      end
    end
    assign cur[g]  = cur_q;
    assign prev[g] = prev_q;
  end

endmodule

// File: rtl/tfs_fis_tx.sv
module tfs_fis_tx #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [N_WORDS-1:0][WORD_W-1:0] load_words,
  input  logic                          ready,
  output logic                          valid,
  output logic [WORD_W-1:0]             data,
  output logic                          last,
  output logic                          busy
);

  localparam int CW = $clog2(N_WORDS + 1);

  logic [N_WORDS-1:0][WORD_W-1:0] word_q;
  logic [CW-1:0]                  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      left_q <= '0;
    end else if (left_q == '0) begin
      if (start) begin
        word_q <= load_words;
        left_q <= CW'(N_WORDS);
      end
    end else if (ready) begin
      for (int i = 0; i < N_WORDS; i++) begin
        word_q[i] <= (i == N_WORDS - 1) ? '0 : word_q[(i + 1) % N_WORDS];
      end
      left_q <= left_q - 1'b1;
    end
  end

  assign busy  = (left_q != '0);
  assign valid = busy;
  assign last  = (left_q == CW'(1));
  assign data  = word_q[0];

endmodule

// File: rtl/tfs_shadow_top.sv
module tfs_shadow_top
  import tfs_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int ADDR_W  = 10,
  parameter int DW      = 8,
  parameter int FIS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic [DW-1:0]     dev_status,
  input  logic [DW-1:0]     dev_error,
  output logic              fis_valid,
  input  logic              fis_ready,
  output logic [FIS_W-1:0]  fis_data,
  output logic              fis_last
);

  localparam int CMD_BASE  = (CHANNEL != 0) ? 'h170 : 'h1F0;
  localparam int CTL_ADDR  = (CHANNEL != 0) ? 'h376 : 'h3F6;
  localparam int FIS_WORDS = 5;
  localparam int HOB_BIT   = DW - 1;

  tfs_sel_e sel;
  logic     blk_hit;

  tfs_decode #(.ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .CTL_ADDR(CTL_ADDR)) u_dec (
    .io_addr (io_addr),
    .sel     (sel),
    .blk_hit (blk_hit)
  );

  logic [NUM_PAIRS-1:0]         pair_we;
  logic [NUM_PAIRS-1:0][DW-1:0] pair_cur;
  logic [NUM_PAIRS-1:0][DW-1:0] pair_prev;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_we
    assign pair_we[i] = io_wr && (sel == pair_sel(i));
  end

  tfs_pair_regs #(.N(NUM_PAIRS), .W(DW)) u_pairs (
    .clk   (clk),
    .rst   (rst),
    .we    (pair_we),
    .wdata (io_wdata),
    .cur   (pair_cur),
    .prev  (pair_prev)
  );

  logic [DW-1:0] dev_q;
  logic [DW-1:0] ctl_q;
  logic          hob;

  assign hob = ctl_q[HOB_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q <= '0;
      ctl_q <= '0;
    end else if (io_wr) begin
      if (sel == SEL_DEV) dev_q <= io_wdata;
      if (sel == SEL_CTL) begin
        ctl_q <= io_wdata;
      end else if (blk_hit) begin
        ctl_q[HOB_BIT] <= 1'b0;
      end
    end
  end

  // read path
  logic [DW-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_FEAT: rd_mux = dev_error;
      SEL_CNT:  rd_mux = hob ? pair_prev[P_CNT] : pair_cur[P_CNT];
      SEL_LO:   rd_mux = hob ? pair_prev[P_LO]  : pair_cur[P_LO];
      SEL_MID:  rd_mux = hob ? pair_prev[P_MID] : pair_cur[P_MID];
      SEL_HI:   rd_mux = hob ? pair_prev[P_HI]  : pair_cur[P_HI];
      SEL_DEV:  rd_mux = dev_q;
      SEL_CMD:  rd_mux = dev_status;
      SEL_CTL:  rd_mux = dev_status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_mux;
  end

  // frame snapshot and transmit
  tfs_snap_t                    snap;
  logic [FIS_WORDS-1:0][31:0]   frame;
  logic [FIS_WORDS-1:0][FIS_W-1:0] frame_w;
  logic                         tx_busy;
  logic                         cmd_go;

  always_comb begin
    snap.feat_cur  = pair_cur[P_FEAT];
    snap.feat_prev = pair_prev[P_FEAT];
    snap.cnt_cur   = pair_cur[P_CNT];
    snap.cnt_prev  = pair_prev[P_CNT];
    snap.lo_cur    = pair_cur[P_LO];
    snap.lo_prev   = pair_prev[P_LO];
    snap.mid_cur   = pair_cur[P_MID];
    snap.mid_prev  = pair_prev[P_MID];
    snap.hi_cur    = pair_cur[P_HI];
    snap.hi_prev   = pair_prev[P_HI];
    snap.dev       = dev_q;
    snap.cmd       = io_wdata;
    snap.ctl       = ctl_q;
  end

  assign frame  = build_frame(snap);
  assign cmd_go = io_wr && (sel == SEL_CMD) && !tx_busy;

  for (genvar k = 0; k < FIS_WORDS; k++) begin : g_fw
    assign frame_w[k] = FIS_W'(frame[k]);
  end

  tfs_fis_tx #(.WORD_W(FIS_W), .N_WORDS(FIS_WORDS)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .start      (cmd_go),
    .load_words (frame_w),
    .ready      (fis_ready),
    .valid      (fis_valid),
    .data       (fis_data),
    .last       (fis_last),
    .busy       (tx_busy)
  );

endmodule

// File: rtl/tfs_shadow_chk.sv
module tfs_shadow_chk #(
  parameter int CHANNEL = 0,
  parameter int ADDR_W  = 10,
  parameter int DW      = 8,
  parameter int FIS_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DW-1:0]     io_rdata,
  input logic              fis_valid,
  input logic              fis_ready,
  input logic [FIS_W-1:0]  fis_data,
  input logic              fis_last,
  input logic              hob
);

  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'((CHANNEL != 0) ? 'h170 : 'h1F0);

  logic cmd_wr;
  logic blk_wr;
  assign cmd_wr = io_wr && (io_addr == (CMD_A + ADDR_W'(7)));
  assign blk_wr = io_wr && (io_addr[ADDR_W-1:3] == CMD_A[ADDR_W-1:3]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!fis_valid && io_rdata == '0));

  p_hob_clear_r5: assert property (@(posedge clk) disable iff (rst)
    blk_wr |=> !hob);

  p_start_hdr_r7: assert property (@(posedge clk) disable iff (rst)
    (!fis_valid && cmd_wr) |=> (fis_valid && fis_data[15:0] == 16'h8027));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fis_valid && !fis_ready) |=> (fis_valid && $stable(fis_data) && $stable(fis_last)));

  p_drop_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (fis_valid && fis_ready && fis_last) |=> !fis_valid);

  p_last_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    fis_last |-> fis_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fis_valid) |-> $past(cmd_wr));

endmodule

bind tfs_shadow_top tfs_shadow_chk #(
  .CHANNEL(CHANNEL), .ADDR_W(ADDR_W), .DW(DW), .FIS_W(FIS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_rdata  (io_rdata),
  .fis_valid (fis_valid),
  .fis_ready (fis_ready),
  .fis_data  (fis_data),
  .fis_last  (fis_last),
  .hob       (ctl_q[DW-1])
);

// File: tb/tfs_shadow_top_tb_top.sv
module tfs_shadow_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [9:0] CB  = 10'h1F0;
  localparam logic [9:0] CTL = 10'h3F6;
  localparam logic [7:0] STS = 8'h50;
  localparam logic [7:0] ERR = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0, io_rd = 1'b0, fis_ready = 1'b0;
  logic [9:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic fis_valid, fis_last;
  logic [31:0] fis_data;

  int n_run = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfs_shadow_top dut_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_status(STS), .dev_error(ERR),
    .fis_valid(fis_valid), .fis_ready(fis_ready), .fis_data(fis_data), .fis_last(fis_last)
  );

  // behavioural reference model
  logic [7:0] m_cur[5], m_prev[5];   // 0 feat,1 cnt,2 lo,3 mid,4 hi
  logic [7:0] m_dev, m_ctl, m_rdata;
  logic [31:0] m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cur[i]) begin m_cur[i] = 0; m_prev[i] = 0; end
      m_dev = 0; m_ctl = 0; m_rdata = 0; m_q.delete();
    end else begin
      automatic bit was_empty = (m_q.size() == 0);
      if (io_rd) begin
        if (io_addr == CTL) m_rdata = STS;
        else if (io_addr >= CB && io_addr <= CB + 7) begin
          case (int'(io_addr - CB))
            1: m_rdata = ERR;
            2, 3, 4, 5: m_rdata = m_ctl[7] ? m_prev[io_addr - CB - 1] : m_cur[io_addr - CB - 1];
            6: m_rdata = m_dev;
            7: m_rdata = STS;
            default: m_rdata = 0;
          endcase
        end else m_rdata = 0;
      end
      if (!was_empty && fis_ready) void'(m_q.pop_front());
      if (io_wr) begin
        if (io_addr == CTL) m_ctl = io_wdata;
        else if (io_addr >= CB && io_addr <= CB + 7) begin
          automatic int off = int'(io_addr - CB);
          if (off >= 1 && off <= 5) begin
            m_prev[off-1] = m_cur[off-1]; m_cur[off-1] = io_wdata;
          end
          if (off == 6) m_dev = io_wdata;
          if (off == 7 && was_empty) begin
            m_q.push_back({m_cur[0], io_wdata, 8'h80, 8'h27});
            m_q.push_back({m_dev, m_cur[4], m_cur[3], m_cur[2]});
            m_q.push_back({m_prev[0], m_prev[4], m_prev[3], m_prev[2]});
            m_q.push_back({m_ctl & 8'h7F, 8'h00, m_prev[1], m_cur[1]});
            m_q.push_back(32'h0);
          end
          m_ctl[7] = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check(io_rdata == m_rdata, "R3 rdata vs model", io_rdata, m_rdata);
      check(fis_valid == (m_q.size() != 0), "R8 valid vs model", fis_valid, m_q.size() != 0);
      if (m_q.size() != 0) begin
        check(fis_data == m_q[0], "R7 data vs model", fis_data, m_q[0]);
        check(fis_last == (m_q.size() == 1), "R8 last vs model", fis_last, m_q.size() == 1);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] exp_w[5];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(io_rdata == 8'h00 && !fis_valid, "R1 reset outputs", {fis_valid, io_rdata}, 0);
    cmp_en = 1'b1;
    rd(CB + 2); check(io_rdata == 8'h00, "R1 count after reset", io_rdata, 8'h00);

    // R2/R3 two-entry behaviour
    wr(CB + 2, 8'h12); wr(CB + 2, 8'h34);
    rd(CB + 2); check(io_rdata == 8'h34, "R3 HOB=0 newest", io_rdata, 8'h34);
    wr(CTL, 8'h80);
    rd(CB + 2); check(io_rdata == 8'h12, "R3 HOB=1 older", io_rdata, 8'h12);
    rd(CB + 3); check(io_rdata == 8'h00, "R3 HOB=1 unwritten", io_rdata, 8'h00);

    // R5 block write clears HOB
    wr(CB + 3, 8'hA1);
    rd(CB + 2); check(io_rdata == 8'h34, "R5 HOB cleared by block write", io_rdata, 8'h34);

    // R2 oldest dropped
    wr(CB + 4, 8'h01); wr(CB + 4, 8'h02); wr(CB + 4, 8'h03);
    rd(CB + 4); check(io_rdata == 8'h03, "R2 current after three", io_rdata, 8'h03);
    wr(CTL, 8'h80);
    rd(CB + 4); check(io_rdata == 8'h02, "R2 previous after three", io_rdata, 8'h02);

    // R6 read-only sources and device register
    rd(CB + 1); check(io_rdata == ERR, "R6 features reads error", io_rdata, ERR);
    rd(CB + 7); check(io_rdata == STS, "R6 command reads status", io_rdata, STS);
    rd(CTL);    check(io_rdata == STS, "R6 control reads status", io_rdata, STS);
    wr(CB + 6, 8'hE0);
    rd(CB + 6); check(io_rdata == 8'hE0, "R6 device readback", io_rdata, 8'hE0);

    // R4 other channel and stray addresses ignored
    wr(10'h376, 8'h80);
    rd(CB + 2); check(io_rdata == 8'h34, "R4 secondary control ignored", io_rdata, 8'h34);
    wr(10'h172, 8'h99);
    rd(CB + 2); check(io_rdata == 8'h34, "R4 secondary count ignored", io_rdata, 8'h34);
    rd(10'h3F7); check(io_rdata == 8'h00, "R4 stray read zero", io_rdata, 8'h00);

    // R7 frame contents, R8 stall
    wr(CB + 1, 8'h11); wr(CB + 1, 8'h22);
    wr(CTL, 8'h02);
    exp_w[0] = 32'h22258027; exp_w[1] = 32'hE00003A1; exp_w[2] = 32'h11000200;
    exp_w[3] = 32'h02001234; exp_w[4] = 32'h0;
    fis_ready = 1'b0;
    wr(CB + 7, 8'h25);
    check(fis_valid == 1'b1, "R7 valid after command", fis_valid, 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(fis_data == exp_w[k], "R7 frame word", fis_data, exp_w[k]);
      check(fis_last == (k == 4), "R8 last flag", fis_last, k == 4);
      fis_ready = 1'b1;
      @(negedge clk);
      fis_ready = 1'b0;
    end
    check(fis_valid == 1'b0, "R8 valid drops after last", fis_valid, 0);

    // R9 second command while pending rejected
    wr(CB + 7, 8'hC8);
    wr(CB + 7, 8'hEC);
    check(fis_data[23:16] == 8'hC8, "R9 in-flight command kept", fis_data[23:16], 8'hC8);
    fis_ready = 1'b1;
    repeat (5) @(negedge clk);
    fis_ready = 1'b0;
    check(fis_valid == 1'b0, "R9 no second frame", fis_valid, 0);
    repeat (3) @(negedge clk);
    check(fis_valid == 1'b0, "R9 still idle", fis_valid, 0);

    // R8 back-to-back accept with ready held high
    fis_ready = 1'b1;
    wr(CB + 7, 8'h24);
    repeat (4) @(negedge clk);
    check(fis_last == 1'b1, "R8 last at fifth word", fis_last, 1);
    @(negedge clk);
    check(fis_valid == 1'b0, "R8 idle after stream", fis_valid, 0);
    fis_ready = 1'b0;

    done = 1'b1;
    summary();
  end

endmodule